// File: doc/BRIEF.md
# Sleep-State Rail Sequencer

This controller sits beside the standby regulators of a computer board and turns two sleep-request pins into power-rail switch commands. It runs on a free-running standby clock. It filters the two pins, resolves the request into one of three system states (working, suspend-to-RAM, soft-off) and drives three digital controls. The first enables the standby switch that feeds the 5 V dual rail from the standby supply. The second releases the open-drain pull-down that holds the main-rail pass switches off. The third keeps the 3.3 V standby LDO regulating or parks it in standby.

The block also orders the state changes. A wake is held back until the 12 V rail reports good and then for three soft-start intervals. Entry into suspend from the working state is delayed, while soft-off takes effect at once. A request that would move soft-off straight into suspend is refused. While the standby supply is below its power-on threshold, every output sits in its safe low state. A parameter selects a variant that keeps the 5 V dual rail fed in soft-off. All intervals are counted in clock cycles and set by parameters.

Top module: `acpi_rail_seq`

## Requirements
- R1: The filtered pins select the requested state: `slp_off_n` low requests soft-off, `slp_off_n` high with `slp_ram_n` low requests suspend, and both high request the working state.
- R2: Outputs per state, written {`main_sw_release`,`ldo_active`,`sb5_sw_on`}: working = 100, suspend = 011, soft-off = 01K, where K is the keep-on parameter.
- R3: With `KEEP_5V_SOFTOFF` = 1, `sb5_sw_on` is high in soft-off. With the default 0 it is low.
- R4: A request for suspend while in soft-off is ignored, and the outputs keep their soft-off values. A wake that started from soft-off and then sees a suspend request returns to soft-off.
- R5: After a suspend request is accepted in the working state, the working outputs are held for `SUSP_DLY_CYCLES` cycles before the suspend outputs appear. A new working request during that wait cancels it.
- R6: After a soft-off request is accepted in the working state, or during the suspend wait, the soft-off outputs appear on the next cycle with no delay.
- R7: The working outputs appear only after the synchronized `rail12_ok` has been high without a break for `SS_REPS` × `SS_CYCLES` cycles. All three outputs change in the same cycle.
- R8: A pin pattern is accepted only after it has stayed unchanged for `FILT_CYCLES` consecutive synchronized cycles. Shorter pulses have no effect.
- R9: While `sb_por_ok` is low, all three outputs are 0 and the filter and timers are cleared. When it returns, the block starts in soft-off.
- R10: During the wake wait the sleep outputs are held. A drop of `rail12_ok` restarts the wait from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sb_por_ok | input | 1 | Standby supply above its power-on threshold |
| rail12_ok | input | 1 | 12 V rail above its good threshold (asynchronous) |
| slp_ram_n | input | 1 | Suspend-to-RAM request, active low (asynchronous) |
| slp_off_n | input | 1 | Soft-off request, active low (asynchronous) |
| sb5_sw_on | output | 1 | 1 = standby switch feeds the 5 V dual rail |
| main_sw_release | output | 1 | 1 = open-drain released, main pass switches on |
| ldo_active | output | 1 | 1 = 3.3 V standby LDO regulating, 0 = standby |

## Verification
The bound checker watches, on every cycle, the rules that hold between the outputs and the internal events. The working outputs may rise only after the wake timer has finished, and all three must switch together. Soft-off must never lead to suspend. A soft-off request must take effect on the next cycle. The suspend outputs must follow the end of the delay timer. A filtered pin value may change only after a stable synchronized input. Power-on reset must force the safe state. The directed scenarios cover what needs a whole history to judge: the exact length of the wake and suspend waits, the restart of the wake count when the 12 V flag drops, the rejection of short pulses, and the soft-off value of the 5 V switch in both parameter variants.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;

  typedef enum logic [1:0] {
    REQ_SOFTOFF = 2'd0,
    REQ_SUSPEND = 2'd1,
    REQ_ACTIVE  = 2'd2
  } req_e;

  typedef enum logic [2:0] {
    ST_NOPWR     = 3'd0,
    ST_SOFTOFF   = 3'd1,
    ST_SUSPEND   = 3'd2,
    ST_WAKE_WAIT = 3'd3,
    ST_ACTIVE    = 3'd4,
    ST_SUSP_PEND = 3'd5
  } state_e;

  typedef struct packed {
    logic main_release;
    logic ldo_active;
    logic sb5_on;
  } rail_ctl_t;

  // Pin pattern to requested state; soft-off request dominates.
  function automatic req_e decode_pins(input logic off_n, input logic ram_n);
    if (!off_n)      return REQ_SOFTOFF;
    else if (!ram_n) return REQ_SUSPEND;
    else             return REQ_ACTIVE;
  endfunction

  // Output drive for each state.
  function automatic rail_ctl_t outputs_for(input state_e st, input logic keep_on,
                                            input logic from_susp);
    rail_ctl_t c;
    c = '0;
    case (st)
      ST_SOFTOFF:   begin c.ldo_active = 1'b1; c.sb5_on = keep_on; end
      ST_SUSPEND:   begin c.ldo_active = 1'b1; c.sb5_on = 1'b1; end
      ST_WAKE_WAIT: begin c.ldo_active = 1'b1; c.sb5_on = keep_on | from_susp; end
      ST_ACTIVE,
      ST_SUSP_PEND: c.main_release = 1'b1;
      default:      c = '0;
    endcase
    return c;
  endfunction

  // Total wake wait in cycles.
  function automatic longint wake_cycles(input longint interval, input longint reps);
    return interval * reps;
  endfunction

endpackage

// File: rtl/acpi_sync.sv
module acpi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/acpi_pin_filter.sv
module acpi_pin_filter #(
  parameter int W           = 2,
  parameter int FILT_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

  logic [W-1:0]     cand;
  logic [CNT_W-1:0] cnt;
  logic             same;
  logic             hit;

  assign same = (d == cand);
  assign hit  = same && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand <= '0;
      cnt  <= '0;
      q    <= '0;
    end else if (clr) begin
      cand <= '0;
      cnt  <= '0;
      q    <= '0;
    end else if (!same) begin
      cand <= d;
      cnt  <= '0;
    end else if (hit) begin
      q <= cand;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/acpi_interval_timer.sv
module acpi_interval_timer #(
  parameter int LEN  = 20,
  parameter int REPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int CYC_W = $clog2(LEN + 1);
  localparam int REP_W = $clog2(REPS + 1);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(LEN - 1);
  localparam logic [REP_W-1:0] REP_END  = REP_W'(REPS);

  logic [CYC_W-1:0] cyc;
  logic [REP_W-1:0] rep;

  assign done = (rep == REP_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
      rep <= '0;
    end else if (clr) begin
      cyc <= '0;
      rep <= '0;
    end else if (run && !done) begin
      if (cyc == LAST_CYC) begin
        cyc <= '0;
        rep <= rep + 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/acpi_rail_seq.sv
module acpi_rail_seq
  import acpi_seq_pkg::*;
#(
  parameter int FILT_CYCLES     = 250,
  parameter int SUSP_DLY_CYCLES = 15000,
  parameter int SS_CYCLES       = 2050000,
  parameter int SS_REPS         = 3,
  parameter int SYNC_STAGES     = 2,
  parameter bit KEEP_5V_SOFTOFF = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sb_por_ok,
  input  logic rail12_ok,
  input  logic slp_ram_n,
  input  logic slp_off_n,
  output logic sb5_sw_on,
  output logic main_sw_release,
  output logic ldo_active
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] sync_q;
  logic              rail12_s;
  logic [1:0]        pin_sync;
  logic [1:0]        pin_filt;
  req_e              req;
  state_e            state, nxt;
  logic              from_susp;
  logic              wake_done, susp_done;
  logic              wake_run, wake_clr, susp_run, susp_clr;
  rail_ctl_t         ctl;

  acpi_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({rail12_ok, slp_off_n, slp_ram_n}),
    .q(sync_q)
  );

  assign rail12_s = sync_q[2];
  assign pin_sync = sync_q[1:0];

  acpi_pin_filter #(.W(2), .FILT_CYCLES(FILT_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .clr(!sb_por_ok),
    .d(pin_sync), .q(pin_filt)
  );

  assign req = decode_pins(pin_filt[1], pin_filt[0]);

  assign wake_run = (state == ST_WAKE_WAIT) && rail12_s;
  assign wake_clr = !sb_por_ok || (state != ST_WAKE_WAIT) || !rail12_s;

  acpi_interval_timer #(.LEN(SS_CYCLES), .REPS(SS_REPS)) u_wake_tmr (
    .clk(clk), .rst_n(rst_n), .clr(wake_clr), .run(wake_run), .done(wake_done)
  );

  assign susp_run = (state == ST_SUSP_PEND);
  assign susp_clr = !sb_por_ok || (state != ST_SUSP_PEND);

  acpi_interval_timer #(.LEN(SUSP_DLY_CYCLES), .REPS(1)) u_susp_tmr (
    .clk(clk), .rst_n(rst_n), .clr(susp_clr), .run(susp_run), .done(susp_done)
  );

  always_comb begin
    nxt = state;
    case (state)
      ST_NOPWR:     nxt = ST_SOFTOFF;
      ST_SOFTOFF:   if (req == REQ_ACTIVE) nxt = ST_WAKE_WAIT;
      ST_SUSPEND: begin
        if (req == REQ_ACTIVE)       nxt = ST_WAKE_WAIT;
        else if (req == REQ_SOFTOFF) nxt = ST_SOFTOFF;
      end
      ST_WAKE_WAIT: begin
        if (req == REQ_SOFTOFF)              nxt = ST_SOFTOFF;
        else if (req == REQ_SUSPEND)         nxt = from_susp ? ST_SUSPEND : ST_SOFTOFF;
        else if (wake_done && rail12_s)      nxt = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (req == REQ_SOFTOFF)      nxt = ST_SOFTOFF;
        else if (req == REQ_SUSPEND) nxt = ST_SUSP_PEND;
      end
      ST_SUSP_PEND: begin
        if (req == REQ_SOFTOFF)     nxt = ST_SOFTOFF;
        else if (req == REQ_ACTIVE) nxt = ST_ACTIVE;
        else if (susp_done)         nxt = ST_SUSPEND;
      end
      default: nxt = ST_NOPWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_NOPWR;
      from_susp <= 1'b0;
    end else if (!sb_por_ok) begin
      state     <= ST_NOPWR;
      from_susp <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == ST_SUSPEND)                            from_susp <= 1'b1;
      else if (nxt == ST_SOFTOFF || nxt == ST_NOPWR)    from_susp <= 1'b0;
    end
  end

  assign ctl             = outputs_for(state, KEEP_5V_SOFTOFF, from_susp);
  assign main_sw_release = ctl.main_release;
  assign ldo_active      = ctl.ldo_active;
  assign sb5_sw_on       = ctl.sb5_on;
endmodule

// File: rtl/acpi_rail_seq_chk.sv
module acpi_rail_seq_chk
  import acpi_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sb_por_ok,
  input logic       sb5_sw_on,
  input logic       main_sw_release,
  input logic       ldo_active,
  input state_e     state,
  input req_e       req,
  input logic       from_susp,
  input logic       wake_done,
  input logic       susp_done,
  input logic [1:0] pin_sync,
  input logic [1:0] pin_filt
);
  // R9
  por_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_por_ok |=> (!sb5_sw_on && !main_sw_release && !ldo_active));

  // R4
  no_off_to_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SOFTOFF) |=> (state != ST_SUSPEND));

  // R4
  no_wake_to_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE_WAIT && !from_susp) |=> (state != ST_SUSPEND));

  // R6
  off_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_por_ok && (state == ST_ACTIVE || state == ST_SUSP_PEND) && req == REQ_SOFTOFF)
      |=> (state == ST_SOFTOFF));

  // R7
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_sw_release) |-> $past(wake_done));

  // R7
  switch_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_sw_release) |-> (!ldo_active && !sb5_sw_on && $past(ldo_active)));

  // R5
  susp_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSPEND && $past(state) == ST_SUSP_PEND) |-> $past(susp_done));

  // R8
  filt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_por_ok && $past(sb_por_ok) && !$stable(pin_filt))
      |-> ($past(pin_sync) == pin_filt && $past(pin_sync, 2) == pin_filt));
endmodule

bind acpi_rail_seq acpi_rail_seq_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .sb_por_ok(sb_por_ok),
  .sb5_sw_on(sb5_sw_on),
  .main_sw_release(main_sw_release),
  .ldo_active(ldo_active),
  .state(state),
  .req(req),
  .from_susp(from_susp),
  .wake_done(wake_done),
  .susp_done(susp_done),
  .pin_sync(pin_sync),
  .pin_filt(pin_filt)
);

// File: tb/acpi_rail_seq_tb.sv
module acpi_rail_seq_tb;
  localparam int FILT = 8;
  localparam int SDLY = 40;
  localparam int SS   = 20;
  localparam int REPS = 3;

  // {main_sw_release, ldo_active, sb5_sw_on}
  localparam logic [2:0] O_NONE = 3'b000;
  localparam logic [2:0] O_ACT  = 3'b100;
  localparam logic [2:0] O_SUS  = 3'b011;
  localparam logic [2:0] O_OFF0 = 3'b010;
  localparam logic [2:0] O_OFF1 = 3'b011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sb_por_ok = 1'b0;
  logic rail12_ok = 1'b0;
  logic slp_ram_n = 1'b0;
  logic slp_off_n = 1'b0;
  logic sb5_a, main_a, ldo_a;
  logic sb5_k, main_k, ldo_k;
  int   checks = 0;
  int   errors = 0;
  bit   reported = 1'b0;

  always #2 clk = ~clk;

  acpi_rail_seq #(.FILT_CYCLES(FILT), .SUSP_DLY_CYCLES(SDLY), .SS_CYCLES(SS),
                  .SS_REPS(REPS), .KEEP_5V_SOFTOFF(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .sb_por_ok(sb_por_ok), .rail12_ok(rail12_ok),
    .slp_ram_n(slp_ram_n), .slp_off_n(slp_off_n),
    .sb5_sw_on(sb5_a), .main_sw_release(main_a), .ldo_active(ldo_a));

  acpi_rail_seq #(.FILT_CYCLES(FILT), .SUSP_DLY_CYCLES(SDLY), .SS_CYCLES(SS),
                  .SS_REPS(REPS), .KEEP_5V_SOFTOFF(1'b1)) u_dut_keep (
    .clk(clk), .rst_n(rst_n), .sb_por_ok(sb_por_ok), .rail12_ok(rail12_ok),
    .slp_ram_n(slp_ram_n), .slp_off_n(slp_off_n),
    .sb5_sw_on(sb5_k), .main_sw_release(main_k), .ldo_active(ldo_k));

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // R9: reset and power-on reset hold the safe state, then soft-off
  task automatic t_power_up();
    wait_cyc(3);
    check("R9 in reset", {main_a, ldo_a, sb5_a}, O_NONE);
    rst_n = 1'b1;
    wait_cyc(5);
    check("R9 por low", {main_a, ldo_a, sb5_a}, O_NONE);
    sb_por_ok = 1'b1;
    wait_cyc(10);
    check("R2 soft-off", {main_a, ldo_a, sb5_a}, O_OFF0);
    check("R3 keep soft-off", {main_k, ldo_k, sb5_k}, O_OFF1);
  endtask

  // R4: suspend pattern from soft-off is refused
  task automatic t_illegal();
    slp_off_n = 1'b1; slp_ram_n = 1'b0;
    wait_cyc(30);
    check("R4 blocked", {main_a, ldo_a, sb5_a}, O_OFF0);
    slp_off_n = 1'b0;
    wait_cyc(20);
  endtask

  // R8: a pulse shorter than the filter window is ignored
  task automatic t_glitch();
    rail12_ok = 1'b1;
    wait_cyc(5);
    slp_off_n = 1'b1; slp_ram_n = 1'b1;
    wait_cyc(FILT / 2);
    slp_off_n = 1'b0; slp_ram_n = 1'b0;
    wait_cyc(100);
    check("R8 glitch", {main_a, ldo_a, sb5_a}, O_OFF0);
    rail12_ok = 1'b0;
    wait_cyc(5);
  endtask

  // R1 R7 R10: wake waits on the 12 V flag and restarts on a drop
  task automatic t_wake();
    slp_off_n = 1'b1; slp_ram_n = 1'b1;
    wait_cyc(100);
    check("R7 no 12V", {main_a, ldo_a, sb5_a}, O_OFF0);
    check("R10 hold keep", {main_k, ldo_k, sb5_k}, O_OFF1);
    rail12_ok = 1'b1;
    wait_cyc(30);
    rail12_ok = 1'b0;
    wait_cyc(5);
    rail12_ok = 1'b1;
    wait_cyc(55);
    check("R10 restart", {main_a, ldo_a, sb5_a}, O_OFF0);
    wait_cyc(15);
    check("R1 R7 active", {main_a, ldo_a, sb5_a}, O_ACT);
    check("R2 active keep", {main_k, ldo_k, sb5_k}, O_ACT);
  endtask

  // R5: suspend entry waits the delay
  task automatic t_suspend();
    slp_ram_n = 1'b0;
    wait_cyc(44);
    check("R5 held", {main_a, ldo_a, sb5_a}, O_ACT);
    wait_cyc(16);
    check("R5 R2 suspend", {main_a, ldo_a, sb5_a}, O_SUS);
    check("R1 suspend keep", {main_k, ldo_k, sb5_k}, O_SUS);
    slp_ram_n = 1'b1;
    wait_cyc(100);
    check("R7 wake from suspend", {main_a, ldo_a, sb5_a}, O_ACT);
  endtask

  // R6: soft-off entry is immediate
  task automatic t_softoff();
    slp_off_n = 1'b0;
    wait_cyc(14);
    check("R6 soft-off", {main_a, ldo_a, sb5_a}, O_OFF0);
    check("R3 R6 keep", {main_k, ldo_k, sb5_k}, O_OFF1);
  endtask

  // R9: power-on reset drop from working
  task automatic t_por();
    slp_off_n = 1'b1; slp_ram_n = 1'b1;
    wait_cyc(100);
    check("R9 pre active", {main_a, ldo_a, sb5_a}, O_ACT);
    sb_por_ok = 1'b0;
    wait_cyc(2);
    check("R9 por drop", {main_a, ldo_a, sb5_a}, O_NONE);
    check("R9 por drop keep", {main_k, ldo_k, sb5_k}, O_NONE);
    sb_por_ok = 1'b1;
    wait_cyc(3);
    check("R9 restart soft-off", {main_a, ldo_a, sb5_a}, O_OFF0);
    wait_cyc(100);
    check("R9 rewake", {main_a, ldo_a, sb5_a}, O_ACT);
  endtask

  initial begin
    t_power_up();
    t_illegal();
    t_glitch();
    t_wake();
    t_suspend();
    t_softoff();
    t_por();
    report();
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run expired, actual hung expected finish");
    report();
    $finish;
  end
endmodule